// File: doc/BRIEF.md
# Receive Frame Status Word Builder

This block sits beside a receive path and follows a received Ethernet frame one byte at a time. It counts the bytes, keeps the first few header bytes it needs, and gathers the error indications that arrive during the frame. These are the PHY receive-error line, a collision input and a no-buffer flag, together with the CRC result and a misalignment (dribble) flag that are sampled on the final byte. When the frame ends, the block packs all of this into one 32-bit status word. That word is handed to the write-back logic for the first word of the receive descriptor.

A frame opens on a byte that carries the start marker and closes on a byte that carries the end marker. Markers count only together with the byte-valid strobe. Idle cycles inside a frame are allowed. The status word and a one-cycle write strobe appear on the clock after the closing byte. The word then holds its value until the next frame completes.

Top module: `rx_status_builder`

## Requirements
- R1: `status_wr` is high for exactly the one cycle after a closing byte (`rx_vld` and `rx_eof` high inside a frame, or on the opening byte). An end marker without `rx_vld`, or outside a frame, starts no write. `status_word` changes only in the cycle `status_wr` is high.
- R2: Bits 29:16 hold the number of bytes from the opening byte to the closing byte, both included. The count saturates at 16383.
- R3: Bit 15 is the OR of bits 14, 11, 7, 6 and 1.
- R4: Bit 7 (too long) is 1 exactly when the length exceeds 1518.
- R5: Bit 6 (late collision) is 1 when `coll_det` was high in some frame cycle in which more than 64 bytes had been received, counting the byte of that cycle.
- R6: Bit 5 (type frame) is 1 when the big-endian value of bytes 12 and 13 (0-based) exceeds 1500. It is forced to 0 when the length is below 14.
- R7: Bit 11 (runt) is 1 when the length is below 64, or when `coll_det` was high in a frame cycle with 64 or fewer bytes received. Bit 1 (CRC error) is `crc_bad` sampled on the closing byte and is forced to 0 for a runt.
- R8: Bit 10 (multicast) equals bit 0 of byte 0.
- R9: Bit 3 is 1 when `phy_rx_err` was high in any frame cycle. Bit 2 is `dribble` sampled on the closing byte.
- R10: Bit 14 (no buffer) is 1 when `no_buf` was high in any frame cycle.
- R11: Bits 9 and 8 (first and last descriptor) are 1. Bits 31, 30, 13, 12, 4 and 0 are 0.
- R12: After reset, `status_wr` is 0 and `status_word` is 0.
- R13: A start marker with `rx_vld` inside an open frame restarts the frame. Earlier bytes and flags are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Byte strobe |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of frame marker |
| rx_eof | input | 1 | Last byte of frame marker |
| phy_rx_err | input | 1 | PHY receive-error indication |
| coll_det | input | 1 | Collision indication |
| crc_bad | input | 1 | CRC check failed, valid on the closing byte |
| dribble | input | 1 | Frame not byte-aligned, valid on the closing byte |
| no_buf | input | 1 | No receive buffer available |
| status_word | output | 32 | Packed frame status |
| status_wr | output | 1 | One-cycle write-back strobe |

## Verification
A wrong byte count or a stale captured header byte shows up in the first status word written after it. It appears as a wrong length, a wrong type or runt flag, or a wrong multicast bit, exactly one cycle after the closing byte. A sticky flag that fails to clear on a restart or a new frame leaks into the next frame's word. A wrong collision threshold swaps the runt and late-collision bits only when the collision falls on byte 64 or 65. The bench therefore places collisions on both sides of that edge and compares the whole word on every clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int LEN_W = 14;

  typedef struct packed {
    logic             own;
    logic             filt_fail;
    logic [LEN_W-1:0] len;
    logic             err_sum;
    logic             no_buf;
    logic [1:0]       rsvd_hi;
    logic             runt;
    logic             mcast;
    logic             first_d;
    logic             last_d;
    logic             too_long;
    logic             late_coll;
    logic             type_frm;
    logic             rsvd_mid;
    logic             phy_err;
    logic             dribble;
    logic             crc_err;
    logic             rsvd_lo;
  } rx_stat_t;
endpackage

// File: rtl/rxs_frame_len.sv
module rxs_frame_len #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  output logic             start,
  output logic             active,
  output logic             take,
  output logic             done,
  output logic [LEN_W-1:0] seen_cnt
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

  logic             in_q, in_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_now;
  logic             cnt_en;

  always_comb begin
    start    = byte_vld & sof;
    active   = start | in_q;
    take     = byte_vld & active;
    done     = take & eof;
    if (start)                cnt_now = CNT_ONE;
    else if (cnt_q == CNT_MAX) cnt_now = cnt_q;
    else                      cnt_now = cnt_q + CNT_ONE;
    seen_cnt = byte_vld ? cnt_now : cnt_q;
    cnt_en   = take;
    cnt_d    = cnt_now;
    if (start)     in_d = ~eof;
    else if (done) in_d = 1'b0;
    else           in_d = in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= 1'b0;
    else        in_q <= in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_cnt_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q && byte_vld && !sof) |=> (cnt_q >= $past(cnt_q)));

  p_cnt_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && sof) |=> (cnt_q == CNT_ONE));
endmodule

// File: rtl/rxs_hdr_capture.sv
module rxs_hdr_capture #(
  parameter int LEN_W      = 14,
  parameter int MC_POS     = 1,
  parameter int TYPE_POS   = 13,
  parameter int TYPE_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [LEN_W-1:0]        seen_cnt,
  input  logic [7:0]              data,
  output logic                    mcast,
  output logic [8*TYPE_BYTES-1:0] type_val
);
  logic mc_q, mc_d, mc_en;

  always_comb begin
    mc_en = take && (seen_cnt == LEN_W'(MC_POS));
    mc_d  = mc_en ? data[0] : mc_q;
    mcast = mc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mc_q <= 1'b0;
    else if (mc_en) mc_q <= data[0];
  end

  for (genvar g = 0; g < TYPE_BYTES; g++) begin : g_type
    logic [7:0] b_q, b_d;
    logic       b_en;
    always_comb begin
      b_en = take && (seen_cnt == LEN_W'(TYPE_POS + g));
      b_d  = b_en ? data : b_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= '0;
      else if (b_en) b_q <= data;
    end
    assign type_val[8*(TYPE_BYTES-1-g) +: 8] = b_d;
  end

  p_mc_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && (seen_cnt == LEN_W'(MC_POS))) |=> (mc_q == $past(mc_q)));
endmodule

// File: rtl/rxs_err_track.sv
module rxs_err_track #(
  parameter int LEN_W      = 14,
  parameter int LATE_AFTER = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [LEN_W-1:0] seen_cnt,
  input  logic             phy_err,
  input  logic             coll,
  input  logic             no_buf,
  output logic             phy_seen,
  output logic             nobuf_seen,
  output logic             early_coll,
  output logic             late_coll
);
  localparam logic [LEN_W-1:0] LATE_L = LEN_W'(LATE_AFTER);

  typedef struct packed {
    logic phy;
    logic nobuf;
    logic early;
    logic late;
  } flags_t;

  flags_t cur, fl_q, fl_d;
  logic   is_late;

  always_comb begin
    is_late   = seen_cnt > LATE_L;
    cur.phy   = phy_err;
    cur.nobuf = no_buf;
    cur.early = coll & ~is_late;
    cur.late  = coll & is_late;
    if (start)       fl_d = cur;
    else if (active) fl_d = fl_q | cur;
    else             fl_d = fl_q;
    phy_seen   = fl_d.phy;
    nobuf_seen = fl_d.nobuf;
    early_coll = fl_d.early;
    late_coll  = fl_d.late;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fl_q <= '0;
    else if (active) fl_q <= fl_d;
  end

  p_phy_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q.phy && !start) |=> fl_q.phy);

  p_nobuf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q.nobuf && !start) |=> fl_q.nobuf);
endmodule

// File: rtl/rx_status_builder.sv
module rx_status_builder
  import rxs_pkg::*;
#(
  parameter int RUNT_MIN   = 64,
  parameter int MAX_LEN    = 1518,
  parameter int TYPE_LIMIT = 1500,
  parameter int LATE_AFTER = 64,
  parameter int TYPE_OFS   = 12,
  parameter int TYPE_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_vld,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        phy_rx_err,
  input  logic        coll_det,
  input  logic        crc_bad,
  input  logic        dribble,
  input  logic        no_buf,
  output logic [31:0] status_word,
  output logic        status_wr
);
  localparam int TYPE_POS = TYPE_OFS + 1;
  localparam int HDR_MIN  = TYPE_OFS + TYPE_BYTES;

  logic                    start, active, take, done;
  logic [LEN_W-1:0]        seen_cnt;
  logic                    mcast;
  logic [8*TYPE_BYTES-1:0] type_val;
  logic                    phy_seen, nobuf_seen, early_coll, late_coll;
  logic                    runt;
  rx_stat_t                stat_new;
  logic [31:0]             word_q, word_d;
  logic                    wr_q, wr_d;

  rxs_frame_len #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .byte_vld(rx_vld), .sof(rx_sof), .eof(rx_eof),
    .start(start), .active(active), .take(take), .done(done), .seen_cnt(seen_cnt)
  );

  rxs_hdr_capture #(
    .LEN_W(LEN_W), .MC_POS(1), .TYPE_POS(TYPE_POS), .TYPE_BYTES(TYPE_BYTES)
  ) u_hdr (
    .clk(clk), .rst_n(rst_n), .take(take), .seen_cnt(seen_cnt), .data(rx_data),
    .mcast(mcast), .type_val(type_val)
  );

  rxs_err_track #(.LEN_W(LEN_W), .LATE_AFTER(LATE_AFTER)) u_err (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active), .seen_cnt(seen_cnt),
    .phy_err(phy_rx_err), .coll(coll_det), .no_buf(no_buf),
    .phy_seen(phy_seen), .nobuf_seen(nobuf_seen),
    .early_coll(early_coll), .late_coll(late_coll)
  );

  always_comb begin
    runt               = (seen_cnt < LEN_W'(RUNT_MIN)) | early_coll;
    stat_new           = '0;
    stat_new.len       = seen_cnt;
    stat_new.no_buf    = nobuf_seen;
    stat_new.runt      = runt;
    stat_new.mcast     = mcast;
    stat_new.first_d   = 1'b1;
    stat_new.last_d    = 1'b1;
    stat_new.too_long  = seen_cnt > LEN_W'(MAX_LEN);
    stat_new.late_coll = late_coll;
    stat_new.type_frm  = (seen_cnt >= LEN_W'(HDR_MIN)) &&
                         (type_val > (8*TYPE_BYTES)'(TYPE_LIMIT));
    stat_new.phy_err   = phy_seen;
    stat_new.dribble   = dribble;
    stat_new.crc_err   = crc_bad & ~runt;
    stat_new.err_sum   = stat_new.crc_err | stat_new.late_coll | stat_new.too_long |
                         stat_new.runt | stat_new.no_buf;
    word_d             = done ? stat_new : word_q;
    wr_d               = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      wr_q   <= wr_d;
    end
  end

  assign status_word = word_q;
  assign status_wr   = wr_q;

  p_wr_after_eof_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |-> $past(rx_vld && rx_eof));

  p_word_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !status_wr |-> $stable(status_word));

  p_err_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |-> (status_word[15] == (status_word[14] | status_word[11] |
                   status_word[7] | status_word[6] | status_word[1])));

  p_too_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && status_word[29:16] <= 14'(MAX_LEN)) |-> !status_word[7]);

  p_late_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && status_word[6]) |-> (status_word[29:16] > 14'(LATE_AFTER)));

  p_type_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && status_word[29:16] < 14'(HDR_MIN)) |-> !status_word[5]);

  p_crc_runt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |-> !(status_word[1] && status_word[11]));

  p_fixed_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |-> (status_word[9:8] == 2'b11 && status_word[31:30] == 2'b00));
endmodule

// File: tb/rx_status_builder_tb_top.sv
module rx_status_builder_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst_n, rx_vld, rx_sof, rx_eof, phy_rx_err, coll_det, crc_bad, dribble, no_buf;
  logic [7:0]  rx_data;
  logic [31:0] status_word;
  logic        status_wr;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  rx_status_builder dut_i (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .phy_rx_err(phy_rx_err), .coll_det(coll_det), .crc_bad(crc_bad),
    .dribble(dribble), .no_buf(no_buf), .status_word(status_word), .status_wr(status_wr)
  );

  // behavioural reference model
  bit          m_in, m_pe, m_nb, m_ec, m_lc;
  int          m_cnt;
  logic [7:0]  m_bytes[$];
  logic        exp_wr;
  logic [31:0] exp_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_in = 0; m_cnt = 0; exp_wr = 0; exp_word = '0;
      m_pe = 0; m_nb = 0; m_ec = 0; m_lc = 0;
      m_bytes.delete();
    end else begin
      exp_wr = 0;
      if (rx_vld && rx_sof) begin
        m_in = 1; m_cnt = 0; m_bytes.delete();
        m_pe = 0; m_nb = 0; m_ec = 0; m_lc = 0;
      end
      if (m_in) begin
        if (rx_vld) begin
          m_cnt++;
          if (m_bytes.size() < 16) m_bytes.push_back(rx_data);
        end
        if (phy_rx_err) m_pe = 1;
        if (no_buf) m_nb = 1;
        if (coll_det) begin
          if (m_cnt <= 64) m_ec = 1; else m_lc = 1;
        end
        if (rx_vld && rx_eof) begin
          int  len;
          bit  runt, ce, ft, tl;
          len  = (m_cnt > 16383) ? 16383 : m_cnt;
          runt = (len < 64) || m_ec;
          ce   = crc_bad && !runt;
          ft   = (len >= 14) && ({m_bytes[12], m_bytes[13]} > 16'd1500);
          tl   = len > 1518;
          exp_word        = '0;
          exp_word[29:16] = len[13:0];
          exp_word[15]    = ce | m_lc | tl | runt | m_nb;
          exp_word[14]    = m_nb;
          exp_word[11]    = runt;
          exp_word[10]    = m_bytes[0][0];
          exp_word[9]     = 1'b1;
          exp_word[8]     = 1'b1;
          exp_word[7]     = tl;
          exp_word[6]     = m_lc;
          exp_word[5]     = ft;
          exp_word[3]     = m_pe;
          exp_word[2]     = dribble;
          exp_word[1]     = ce;
          exp_wr = 1;
          m_in   = 0;
        end
      end
    end
  end

  task automatic field(input string tag, input int hi, input int lo);
    for (int b = lo; b <= hi; b++) begin
      if (status_word[b] !== exp_word[b]) begin
        errors++;
        $display("FAIL %s word[%0d:%0d] actual %h expected %h", tag, hi, lo,
                 status_word, exp_word);
        break;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      checks++;
      if (status_wr !== exp_wr) begin
        errors++;
        $display("FAIL R1 status_wr actual %b expected %b", status_wr, exp_wr);
      end
      checks++;
      if (status_word !== exp_word) begin
        field("R2 length", 29, 16);
        field("R3 summary", 15, 15);
        field("R4 too long", 7, 7);
        field("R5 late collision", 6, 6);
        field("R6 type", 5, 5);
        field("R7 runt", 11, 11);
        field("R7 crc", 1, 1);
        field("R8 multicast", 10, 10);
        field("R9 phy error", 3, 3);
        field("R9 dribble", 2, 2);
        field("R10 no buffer", 14, 14);
        field("R11 descriptor marks", 9, 8);
        field("R11 zero bits", 31, 30);
        field("R11 zero bits", 13, 12);
        field("R11 zero bits", 4, 4);
        field("R11 zero bits", 0, 0);
      end
    end
  end

  task automatic clear_in();
    rx_vld = 0; rx_sof = 0; rx_eof = 0; rx_data = '0; phy_rx_err = 0;
    coll_det = 0; crc_bad = 0; dribble = 0; no_buf = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); clear_in();
    end
  endtask

  task automatic send(input int n, input bit mc, input logic [15:0] typ,
                      input int coll_at, input int pe_at, input int nb_at,
                      input bit crc, input bit drib, input int gap, input bit no_end);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      clear_in();
      rx_vld     = 1;
      rx_sof     = (i == 1);
      rx_eof     = (i == n) && !no_end;
      rx_data    = (i == 1) ? {7'h2a, mc} : (i == 13) ? typ[15:8] :
                   (i == 14) ? typ[7:0] : 8'(i);
      coll_det   = (i == coll_at);
      phy_rx_err = (i == pe_at);
      no_buf     = (i == nb_at);
      crc_bad    = (i == n) && crc;
      dribble    = (i == n) && drib;
      if (gap > 0 && (i % gap) == 0 && i != n) begin
        @(negedge clk);
        clear_in();
        rx_eof = 1;            // marker without byte strobe: ignored (R1)
      end
    end
    if (!no_end) idle(3);
  endtask

  initial begin
    clear_in();
    rst_n = 0;
    idle(3);
    checks++;
    if (status_wr !== 1'b0 || status_word !== 32'h0) begin
      errors++;
      $display("FAIL R12 reset actual %b/%h expected 0/00000000", status_wr, status_word);
    end
    @(negedge clk); rst_n = 1;
    idle(2);
    send(64,   0, 16'h0800, 0, 0, 0, 0, 0, 0, 0);   // R6 type frame, exact minimum
    send(63,   0, 16'h0800, 0, 0, 0, 1, 0, 0, 0);   // R7 runt hides CRC
    send(80,   0, 16'h0040, 0, 0, 0, 1, 0, 0, 0);   // R7 CRC error, R3
    send(13,   0, 16'hffff, 0, 0, 0, 0, 0, 0, 0);   // R6 short frame
    send(14,   0, 16'd1500, 0, 0, 0, 0, 0, 0, 0);   // R6 at limit
    send(14,   0, 16'd1501, 0, 0, 0, 0, 0, 0, 0);   // R6 above limit
    send(1518, 0, 16'h0800, 0, 0, 0, 0, 0, 0, 0);   // R4 boundary
    send(1519, 0, 16'h0800, 0, 0, 0, 0, 0, 0, 0);   // R4 too long
    send(100,  0, 16'h0800, 64, 0, 0, 0, 0, 0, 0);  // R7 early collision
    send(100,  0, 16'h0800, 65, 0, 0, 0, 0, 0, 0);  // R5 late collision
    send(90,   1, 16'h0800, 0, 10, 0, 0, 1, 7, 0);  // R8 R9 with gaps
    send(70,   0, 16'h0800, 0, 0, 50, 0, 0, 0, 0);  // R10
    send(1,    1, 16'h0000, 0, 0, 0, 1, 0, 0, 0);   // R2 single byte
    send(30,   0, 16'h0800, 20, 5, 6, 0, 0, 0, 1);  // R13 aborted part
    send(70,   0, 16'h0900, 0, 0, 0, 0, 0, 0, 0);   // R13 restart, clean word
    @(negedge clk); clear_in(); rx_vld = 1; rx_eof = 1; coll_det = 1; // R1 stray end
    idle(4);
    send(16400, 0, 16'h0800, 0, 0, 0, 0, 0, 0, 0);  // R2 saturation, R4
    idle(4);
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule